// File: doc/BRIEF.md
# Out-of-Order Store Queue Controller

This block keeps the program-ordered list of in-flight stores for an out-of-order core in a circular buffer. It uses three pointers. New stores enter at the tail with their sequence number, their byte count and the load-queue tail position at the moment they entered. A commit update carries the youngest retired sequence number, and the stores it covers become eligible for writeback. A writeback pointer walks the eligible stores in order and offers each one to a single memory write port. A store that the port refuses is held until the port sends a retry strobe. The head frees entries as the memory side reports write completions.

A squash update removes young, uncommitted stores from the tail end. It never removes a store that has already been made eligible, because such a store is architecturally committed. One slot more than the configured capacity is held in storage, so a full ring and an empty ring are never confused. The controller reports the free-slot count and full and empty flags. It also keeps a sticky flag that records any allocation attempted while the ring was full.

Top module: `store_queue_ctrl`

## Requirements
- R1: After reset the ring is empty: `empty`=1, `full`=0, `free_cnt`=CAPACITY, `wr_valid`=0, `alloc_err`=0, `blocked`=0.
- R2: An accepted allocation writes the slot shown on `alloc_slot` (the tail). The tail then steps by one and wraps from slot CAPACITY (the last of CAPACITY+1 slots) to slot 0. After CAPACITY allocations with no retirement, `full`=1.
- R3: An allocation attempted while `full`=1 is rejected and leaves `free_cnt` unchanged. It sets `alloc_err`, which stays at 1 until reset.
- R4: A commit update with value C scans from the head and marks each not-yet-eligible store with sequence number <= C. The scan stops at the first not-yet-eligible store whose sequence number is > C. Eligible stores are offered on `wr_valid` in allocation order, starting the cycle after the commit. Each offer carries the slot, the sequence number, the byte count and the recorded load-queue position.
- R5: An eligible store with a byte count of 0 is completed without raising `wr_valid`, and the writeback pointer moves past it in one cycle.
- R6: An offer with `wr_ready`=0 sets `blocked`. While `blocked`=1, `wr_valid` is raised only in a cycle with `wr_retry`=1, and it re-offers the same slot. `blocked` clears only when such an offer is accepted.
- R7: A completion (`cmpl_valid` with `cmpl_slot`) marks that slot done. The head then advances across every consecutive done slot, stopping at the tail. A done slot behind an unfinished head frees nothing.
- R8: A squash with value S walks back from the tail and frees stores whose sequence number is > S. The walk stops at the first store that is already eligible. The tail moves back by the number of stores freed.
- R9: An allocation and a head retirement in the same cycle both take effect in the occupancy, and therefore in `free_cnt`.
- R10: `free_cnt` equals CAPACITY minus the number of occupied slots. `full`=1 exactly when `free_cnt`=0, and `empty`=1 exactly when `free_cnt`=CAPACITY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_lq_pos | input | LQ_W | Load-queue tail index at allocation |
| alloc_bytes | input | SIZE_W | Byte count of the store (0 = writes nothing) |
| alloc_slot | output | PTR_W | Slot the next allocation uses |
| commit_valid | input | 1 | Commit update strobe |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| wr_valid | output | 1 | Write request offered to memory |
| wr_ready | input | 1 | Memory accepts the offered write |
| wr_retry | input | 1 | Memory invites a blocked write to be re-offered |
| wr_slot | output | PTR_W | Slot of the offered write |
| wr_seq | output | SEQ_W | Sequence number of the offered write |
| wr_bytes | output | SIZE_W | Byte count of the offered write |
| wr_lq_pos | output | LQ_W | Recorded load-queue index of the offered write |
| cmpl_valid | input | 1 | Write completion strobe |
| cmpl_slot | input | PTR_W | Slot whose write completed |
| free_cnt | output | CNT_W | Free slots |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| alloc_err | output | 1 | Sticky: allocation attempted while full |
| blocked | output | 1 | A refused write awaits retry |

## Verification
The bench first fills the ring completely. A design without a sentinel slot, or one that tests fullness wrongly, would overwrite the head or report a wrong free count. It then checks the in-order scan with a zero-byte store. Such a store must retire silently, so a design that issued it, or stalled on it, shows up as a stray `wr_valid` or a stuck pointer. An out-of-order completion must not free anything until the head completes, and a naive head would free the wrong slot. A refused write is followed by a squash that must stop at that committed store. A design that crossed committed entries would lose the pending write, and one that cleared `blocked` on the retry strobe alone would report unblocked while the write is still refused. The last scenario holds an allocation and a retirement in the same cycle, with a tail wrap-around.

// File: rtl/sq_pkg.sv
// Shared types and ring-index helpers for the store queue controller.
// Assumes every offset passed in is no larger than twice the slot count.
package sq_pkg;

    // Writeback port state: flowing, or holding a refused request
    typedef enum logic {
        WB_FLOW = 1'b0,
        WB_HELD = 1'b1
    } wb_mode_e;

    // Ring index base+off, wrapped to the slot count
    function automatic int ring_add(input int base, input int off, input int slots);
        return (base + off) % slots;
    endfunction

    // Ring index base-off, wrapped to the slot count
    function automatic int ring_sub(input int base, input int off, input int slots);
        return (base - off + 2 * slots) % slots;
    endfunction

endpackage

// File: rtl/sq_commit_scan.sv
// Commit scan. Walks the occupied slots from the head and returns the mask
// of slots that become eligible for writeback on this commit. Slots that are
// already eligible are skipped. The walk stops at the first non-eligible slot
// that is younger than the commit value.
// Assumes sequence numbers do not wrap while stores are in flight.
module sq_commit_scan
    import sq_pkg::*;
#(
    parameter int NSLOTS = 5,
    parameter int SEQ_W  = 8,
    parameter int PTR_W  = 3,
    parameter int CNT_W  = 3
) (
    input  logic                              commit_valid,
    input  logic [SEQ_W-1:0]                  commit_seq,
    input  logic [PTR_W-1:0]                  head,
    input  logic [CNT_W-1:0]                  occ,
    input  logic [NSLOTS-1:0][SEQ_W-1:0]      seq_q,
    input  logic [NSLOTS-1:0]                 elig_q,
    output logic [NSLOTS-1:0]                 elig_set
);

    // Ordered scan from head, stopping at the first younger uncommitted store
    always_comb begin
        logic             stop;
        logic [PTR_W-1:0] idx;
        elig_set = '0;
        stop     = 1'b0;
        for (int i = 0; i < NSLOTS; i++) begin
            idx = PTR_W'(ring_add(int'(head), i, NSLOTS));
            if (commit_valid && !stop && (i < int'(occ)) && !elig_q[idx]) begin
                if (seq_q[idx] <= commit_seq) begin
                    elig_set[idx] = 1'b1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sq_squash_walk.sv
// Squash walk. Walks back from the slot just below the tail and marks every
// store younger than the squash value for removal. It stops at the first
// store that is older, or that is already eligible (committed).
// Assumes a squash never arrives in the same cycle as an allocation.
module sq_squash_walk
    import sq_pkg::*;
#(
    parameter int NSLOTS = 5,
    parameter int SEQ_W  = 8,
    parameter int PTR_W  = 3,
    parameter int CNT_W  = 3
) (
    input  logic                              squash_valid,
    input  logic [SEQ_W-1:0]                  squash_seq,
    input  logic [PTR_W-1:0]                  tail,
    input  logic [CNT_W-1:0]                  occ,
    input  logic [NSLOTS-1:0][SEQ_W-1:0]      seq_q,
    input  logic [NSLOTS-1:0]                 elig_q,
    output logic [NSLOTS-1:0]                 kill_mask,
    output logic [CNT_W-1:0]                  kill_cnt
);

    // Backward walk from the tail, halting at committed or older stores
    always_comb begin
        logic             stop;
        logic [PTR_W-1:0] idx;
        kill_mask = '0;
        kill_cnt  = '0;
        stop      = !squash_valid;
        for (int i = 0; i < NSLOTS; i++) begin
            idx = PTR_W'(ring_sub(int'(tail), i + 1, NSLOTS));
            if (!stop && (i < int'(occ))) begin
                if (!elig_q[idx] && (seq_q[idx] > squash_seq)) begin
                    kill_mask[idx] = 1'b1;
                    kill_cnt       = kill_cnt + 1'b1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sq_head_retire.sv
// Head retirement. Counts the consecutive done slots starting at the head,
// limited to the occupied range, and returns them as a mask and a count.
// Assumes the done mask already includes this cycle's completions.
module sq_head_retire
    import sq_pkg::*;
#(
    parameter int NSLOTS = 5,
    parameter int PTR_W  = 3,
    parameter int CNT_W  = 3
) (
    input  logic [PTR_W-1:0]   head,
    input  logic [CNT_W-1:0]   occ,
    input  logic [NSLOTS-1:0]  done_mark,
    output logic [NSLOTS-1:0]  retire_mask,
    output logic [CNT_W-1:0]   retire_cnt
);

    // Forward run of completed slots from the head
    always_comb begin
        logic             stop;
        logic [PTR_W-1:0] idx;
        retire_mask = '0;
        retire_cnt  = '0;
        stop        = 1'b0;
        for (int i = 0; i < NSLOTS; i++) begin
            idx = PTR_W'(ring_add(int'(head), i, NSLOTS));
            if (!stop && (i < int'(occ))) begin
                if (done_mark[idx]) begin
                    retire_mask[idx] = 1'b1;
                    retire_cnt       = retire_cnt + 1'b1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sq_wb_port.sv
// Writeback pointer and memory write handshake. It offers the eligible store
// at the writeback pointer. A zero-byte store is completed locally instead.
// A refused offer is held until a retry strobe, and only an accepted retry
// clears the held state.
// Assumes the writeback pointer never passes the tail. A squash cannot move
// the tail behind it, because every slot it has passed is eligible.
module sq_wb_port
    import sq_pkg::*;
#(
    parameter int NSLOTS = 5,
    parameter int PTR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PTR_W-1:0]   tail,
    input  logic [NSLOTS-1:0]  elig_q,
    input  logic [NSLOTS-1:0]  size_zero,
    input  logic               wr_ready,
    input  logic               wr_retry,
    output logic [PTR_W-1:0]   wb_ptr,
    output logic               wr_valid,
    output logic               zero_hit,
    output logic               held
);

    wb_mode_e   mode_q;
    logic       cand;
    logic       accept;
    logic       advance;

    // Candidate store at the writeback pointer and its handshake
    always_comb begin
        cand     = (wb_ptr != tail) && elig_q[wb_ptr];
        zero_hit = (mode_q == WB_FLOW) && cand && size_zero[wb_ptr];
        wr_valid = (mode_q == WB_HELD) ? wr_retry : (cand && !size_zero[wb_ptr]);
        accept   = wr_valid && wr_ready;
        advance  = accept || zero_hit;
        held     = (mode_q == WB_HELD);
    end

    // Writeback pointer stepping and held-request state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ptr <= '0;
            mode_q <= WB_FLOW;
        end else begin
            if (advance) begin
                wb_ptr <= PTR_W'(ring_add(int'(wb_ptr), 1, NSLOTS));
            end
            if (accept) begin
                mode_q <= WB_FLOW;
            end else if (wr_valid) begin
                mode_q <= WB_HELD;
            end
        end
    end

endmodule

// File: rtl/store_queue_ctrl.sv
// Store queue controller top. Holds the per-slot store records and the head
// and tail pointers, and joins the commit scan, the squash walk, the head
// retirement and the writeback port. One slot beyond CAPACITY serves as the
// sentinel.
// Assumes: a squash and an allocation are never in the same cycle (the squash
// wins and the allocation is dropped); a completion names a slot that was
// written; sequence numbers do not wrap while stores are in flight.
module store_queue_ctrl
    import sq_pkg::*;
#(
    parameter int CAPACITY = 4,
    parameter int SEQ_W    = 8,
    parameter int LQ_W     = 4,
    parameter int SIZE_W   = 4,
    localparam int NSLOTS  = CAPACITY + 1,
    localparam int PTR_W   = (NSLOTS > 2) ? $clog2(NSLOTS) : 1,
    localparam int CNT_W   = $clog2(NSLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic [SEQ_W-1:0]    alloc_seq,
    input  logic [LQ_W-1:0]     alloc_lq_pos,
    input  logic [SIZE_W-1:0]   alloc_bytes,
    output logic [PTR_W-1:0]    alloc_slot,
    input  logic                commit_valid,
    input  logic [SEQ_W-1:0]    commit_seq,
    input  logic                squash_valid,
    input  logic [SEQ_W-1:0]    squash_seq,
    output logic                wr_valid,
    input  logic                wr_ready,
    input  logic                wr_retry,
    output logic [PTR_W-1:0]    wr_slot,
    output logic [SEQ_W-1:0]    wr_seq,
    output logic [SIZE_W-1:0]   wr_bytes,
    output logic [LQ_W-1:0]     wr_lq_pos,
    input  logic                cmpl_valid,
    input  logic [PTR_W-1:0]    cmpl_slot,
    output logic [CNT_W-1:0]    free_cnt,
    output logic                full,
    output logic                empty,
    output logic                alloc_err,
    output logic                blocked
);

    logic [PTR_W-1:0]                head_q, tail_q;
    logic [CNT_W-1:0]                occ_q;
    logic [NSLOTS-1:0][SEQ_W-1:0]    seq_q;
    logic [NSLOTS-1:0][LQ_W-1:0]     lq_q;
    logic [NSLOTS-1:0][SIZE_W-1:0]   size_q;
    logic [NSLOTS-1:0]               elig_q, done_q;
    logic                            err_q;

    logic [NSLOTS-1:0]               elig_set, kill_mask, retire_mask, done_mark, size_zero;
    logic [CNT_W-1:0]                kill_cnt, retire_cnt;
    logic [PTR_W-1:0]                wb_ptr;
    logic                            zero_hit, alloc_ok;

    // Zero-byte flags per slot for the writeback port
    generate
        for (genvar g = 0; g < NSLOTS; g++) begin : g_zero
            assign size_zero[g] = (size_q[g] == '0);
        end
    endgenerate

    sq_commit_scan #(.NSLOTS(NSLOTS), .SEQ_W(SEQ_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_scan (
        .commit_valid (commit_valid),
        .commit_seq   (commit_seq),
        .head         (head_q),
        .occ          (occ_q),
        .seq_q        (seq_q),
        .elig_q       (elig_q),
        .elig_set     (elig_set)
    );

    sq_squash_walk #(.NSLOTS(NSLOTS), .SEQ_W(SEQ_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_squash (
        .squash_valid (squash_valid),
        .squash_seq   (squash_seq),
        .tail         (tail_q),
        .occ          (occ_q),
        .seq_q        (seq_q),
        .elig_q       (elig_q),
        .kill_mask    (kill_mask),
        .kill_cnt     (kill_cnt)
    );

    sq_wb_port #(.NSLOTS(NSLOTS), .PTR_W(PTR_W)) i_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tail      (tail_q),
        .elig_q    (elig_q),
        .size_zero (size_zero),
        .wr_ready  (wr_ready),
        .wr_retry  (wr_retry),
        .wb_ptr    (wb_ptr),
        .wr_valid  (wr_valid),
        .zero_hit  (zero_hit),
        .held      (blocked)
    );

    // Completion marks from memory and from zero-byte stores
    always_comb begin
        done_mark = done_q;
        if (cmpl_valid) begin
            done_mark[cmpl_slot] = 1'b1;
        end
        if (zero_hit) begin
            done_mark[wb_ptr] = 1'b1;
        end
    end

    sq_head_retire #(.NSLOTS(NSLOTS), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_retire (
        .head        (head_q),
        .occ         (occ_q),
        .done_mark   (done_mark),
        .retire_mask (retire_mask),
        .retire_cnt  (retire_cnt)
    );

    // Occupancy flags and the request fields at the writeback pointer
    always_comb begin
        full       = (PTR_W'(ring_add(int'(tail_q), 1, NSLOTS)) == head_q);
        empty      = (head_q == tail_q);
        free_cnt   = CNT_W'(CAPACITY) - occ_q;
        alloc_ok   = alloc_valid && !full && !squash_valid;
        alloc_slot = tail_q;
        alloc_err  = err_q;
        wr_slot    = wb_ptr;
        wr_seq     = seq_q[wb_ptr];
        wr_bytes   = size_q[wb_ptr];
        wr_lq_pos  = lq_q[wb_ptr];
    end

    // Pointer, occupancy and sticky error update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            head_q <= PTR_W'(ring_add(int'(head_q), int'(retire_cnt), NSLOTS));
            if (alloc_ok) begin
                tail_q <= PTR_W'(ring_add(int'(tail_q), 1, NSLOTS));
            end else begin
                tail_q <= PTR_W'(ring_sub(int'(tail_q), int'(kill_cnt), NSLOTS));
            end
            occ_q <= occ_q - retire_cnt - kill_cnt + CNT_W'(alloc_ok);
            if (alloc_valid && full) begin
                err_q <= 1'b1;
            end
        end
    end

    // Per-slot eligibility and done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_q <= '0;
            done_q <= '0;
        end else begin
            elig_q <= (elig_q | elig_set) & ~retire_mask & ~kill_mask;
            done_q <= done_mark & ~retire_mask & ~kill_mask;
            if (alloc_ok) begin
                elig_q[tail_q] <= 1'b0;
                done_q[tail_q] <= 1'b0;
            end
        end
    end

    // Store record capture at the tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= '0;
            lq_q   <= '0;
            size_q <= '0;
        end else if (alloc_ok) begin
            seq_q[tail_q]  <= alloc_seq;
            lq_q[tail_q]   <= alloc_lq_pos;
            size_q[tail_q] <= alloc_bytes;
        end
    end

endmodule

// File: rtl/sq_checker.sv
// Port-level protocol checks for store_queue_ctrl, attached by bind.
// Assumes the reset is synchronous and active low.
module sq_checker #(
    parameter int CAPACITY = 4,
    parameter int PTR_W    = 3,
    parameter int CNT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              wr_retry,
    input logic [PTR_W-1:0]  wr_slot,
    input logic [CNT_W-1:0]  free_cnt,
    input logic              full,
    input logic              empty,
    input logic              alloc_err,
    input logic              blocked
);

    AST_FULL_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (free_cnt == '0)); // R10
    AST_EMPTY_ALL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (free_cnt == CNT_W'(CAPACITY))); // R10
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && full) |=> alloc_err); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_err |=> alloc_err); // R3
    AST_REFUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> blocked); // R6
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !wr_retry) |-> !wr_valid); // R6
    AST_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(wr_slot)); // R6

endmodule

bind store_queue_ctrl sq_checker #(.CAPACITY(CAPACITY), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_sq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_retry    (wr_retry),
    .wr_slot     (wr_slot),
    .free_cnt    (free_cnt),
    .full        (full),
    .empty       (empty),
    .alloc_err   (alloc_err),
    .blocked     (blocked)
);

// File: tb/test_store_queue_ctrl.sv
// Self-checking bench for store_queue_ctrl (CAPACITY=4, five slots).
module test_store_queue_ctrl;

    localparam int CAP = 4;
    localparam int PW  = 3;
    localparam int CW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [7:0]    alloc_seq = '0;
    logic [3:0]    alloc_lq_pos = '0;
    logic [3:0]    alloc_bytes = '0;
    logic [PW-1:0] alloc_slot;
    logic          commit_valid = 1'b0;
    logic [7:0]    commit_seq = '0;
    logic          squash_valid = 1'b0;
    logic [7:0]    squash_seq = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic          wr_retry = 1'b0;
    logic [PW-1:0] wr_slot;
    logic [7:0]    wr_seq;
    logic [3:0]    wr_bytes;
    logic [3:0]    wr_lq_pos;
    logic          cmpl_valid = 1'b0;
    logic [PW-1:0] cmpl_slot = '0;
    logic [CW-1:0] free_cnt;
    logic          full, empty, alloc_err, blocked;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Fill vectors: {seq[23:16], lq[15:12], bytes[11:8], exp_slot[7:4], exp_free_after[3:0]}
    localparam logic [23:0] FILL_VEC [4] = '{
        {8'd10, 4'd1, 4'd4, 4'd0, 4'd3},
        {8'd11, 4'd2, 4'd0, 4'd1, 4'd2},
        {8'd12, 4'd3, 4'd8, 4'd2, 4'd1},
        {8'd13, 4'd4, 4'd2, 4'd3, 4'd0}
    };

    always #2 clk = ~clk;

    store_queue_ctrl #(.CAPACITY(CAP), .SEQ_W(8), .LQ_W(4), .SIZE_W(4)) i_store_queue_ctrl (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_lq_pos(alloc_lq_pos),
        .alloc_bytes(alloc_bytes), .alloc_slot(alloc_slot),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_retry(wr_retry),
        .wr_slot(wr_slot), .wr_seq(wr_seq), .wr_bytes(wr_bytes), .wr_lq_pos(wr_lq_pos),
        .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot),
        .free_cnt(free_cnt), .full(full), .empty(empty),
        .alloc_err(alloc_err), .blocked(blocked)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge, returning at the following falling edge with pulses cleared
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        alloc_valid  = 1'b0;
        commit_valid = 1'b0;
        squash_valid = 1'b0;
        cmpl_valid   = 1'b0;
    endtask

    task automatic do_alloc(input int s, input int lq, input int b);
        alloc_valid  = 1'b1;
        alloc_seq    = 8'(s);
        alloc_lq_pos = 4'(lq);
        alloc_bytes  = 4'(b);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 empty", int'(empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 free", int'(free_cnt), CAP);
        chk("R1 wr_valid", int'(wr_valid), 0);
        chk("R1 alloc_err", int'(alloc_err), 0);
        chk("R1 blocked", int'(blocked), 0);

        // R2 / R10 table-driven fill
        for (int v = 0; v < 4; v++) begin
            chk("R2 alloc slot", int'(alloc_slot), int'(FILL_VEC[v][7:4]));
            do_alloc(int'(FILL_VEC[v][23:16]), int'(FILL_VEC[v][15:12]), int'(FILL_VEC[v][11:8]));
            step();
            chk("R10 free after alloc", int'(free_cnt), int'(FILL_VEC[v][3:0]));
        end
        chk("R2 full after capacity", int'(full), 1);

        // R3 allocation while full is rejected, error sticky
        do_alloc(99, 9, 1);
        step();
        chk("R3 free unchanged", int'(free_cnt), 0);
        chk("R3 alloc_err set", int'(alloc_err), 1);

        // R4 commit 11 marks seq 10 and 11; seq 10 offered next cycle
        commit_valid = 1'b1;
        commit_seq   = 8'd11;
        step();
        chk("R4 wr_valid", int'(wr_valid), 1);
        chk("R4 wr_slot", int'(wr_slot), 0);
        chk("R4 wr_seq", int'(wr_seq), 10);
        chk("R4 wr_bytes", int'(wr_bytes), 4);
        chk("R4 wr_lq_pos", int'(wr_lq_pos), 1);
        step();
        // R5 zero-byte store 11 completes without a request
        chk("R5 no request for zero bytes", int'(wr_valid), 0);
        step();
        // R4 stops at seq 12; R7 slot1 done but head slot0 not
        chk("R4 stop at younger", int'(wr_valid), 0);
        chk("R7 no retire behind head", int'(free_cnt), 0);
        cmpl_valid = 1'b1;
        cmpl_slot  = 3'd0;
        step();
        chk("R7 head retires two", int'(free_cnt), 2);

        // R6 refused write becomes blocked
        wr_ready     = 1'b0;
        commit_valid = 1'b1;
        commit_seq   = 8'd12;
        step();
        chk("R6 offer slot2", int'(wr_valid), 1);
        chk("R6 offer slot", int'(wr_slot), 2);
        step();
        chk("R6 blocked", int'(blocked), 1);
        chk("R6 quiet while held", int'(wr_valid), 0);

        // R8 squash 11 removes seq 13, stops at committed seq 12
        squash_valid = 1'b1;
        squash_seq   = 8'd11;
        step();
        chk("R8 free after squash", int'(free_cnt), 3);
        chk("R8 tail moved back", int'(alloc_slot), 3);
        chk("R8 held store kept", int'(blocked), 1);

        // R6 retry refused stays blocked, then accepted
        wr_retry = 1'b1;
        #0.5;
        chk("R6 retry re-offers", int'(wr_valid), 1);
        chk("R6 retry same slot", int'(wr_slot), 2);
        step();
        chk("R6 still blocked", int'(blocked), 1);
        wr_ready = 1'b1;
        step();
        wr_retry = 1'b0;
        chk("R6 cleared on accept", int'(blocked), 0);
        chk("R6 no further offer", int'(wr_valid), 0);

        // R9 allocation and retirement together
        cmpl_valid = 1'b1;
        cmpl_slot  = 3'd2;
        do_alloc(20, 5, 3);
        step();
        chk("R9 free with both", int'(free_cnt), 3);
        chk("R9 not empty", int'(empty), 0);
        chk("R2 next slot", int'(alloc_slot), 4);
        do_alloc(21, 6, 1);
        step();
        chk("R2 tail wraps to zero", int'(alloc_slot), 0);
        do_alloc(22, 7, 1);
        step();
        chk("R10 free", int'(free_cnt), 1);

        // R4 commit 21 with 22 still pending: two offers, in order
        commit_valid = 1'b1;
        commit_seq   = 8'd21;
        step();
        chk("R4 first seq", int'(wr_seq), 20);
        chk("R4 first slot", int'(wr_slot), 3);
        chk("R4 first lq", int'(wr_lq_pos), 5);
        step();
        chk("R4 second seq", int'(wr_seq), 21);
        chk("R4 second valid", int'(wr_valid), 1);
        step();
        chk("R4 stops before 22", int'(wr_valid), 0);

        // R8 squash 21 removes 22 only
        squash_valid = 1'b1;
        squash_seq   = 8'd21;
        step();
        chk("R8 free", int'(free_cnt), 2);
        chk("R8 tail back", int'(alloc_slot), 0);

        // R7 drain to empty
        cmpl_valid = 1'b1;
        cmpl_slot  = 3'd3;
        step();
        cmpl_valid = 1'b1;
        cmpl_slot  = 3'd4;
        step();
        chk("R7 empty", int'(empty), 1);
        chk("R10 free all", int'(free_cnt), CAP);
        chk("R3 err still set", int'(alloc_err), 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule